// File: doc/BRIEF.md
# Relative Branch Execution Unit

This block executes the two-byte relative branch instructions of a small 8-bit accumulator CPU. The fetch unit hands it one instruction at a time: the opcode, the signed displacement byte, the address the opcode was fetched from, and the current stack pointer. The condition-code flags and the external interrupt pin level come in on plain inputs. The block decides whether the branch is taken and produces the next program counter. It holds off the next instruction until the fixed cycle count of the current one has passed.

The conditional group sits at opcodes 0x20 to 0x2F and is built from pairs. The even opcode of a pair branches when its condition holds, and the odd opcode branches when it fails. The subroutine call at 0xAD always branches. It first writes its return address to the stack, one byte per transfer, over a valid/ready write port. That port may apply back-pressure. Each cycle in which a byte is offered but not accepted stretches the call by one cycle. The offered address and data do not change until the byte is taken. Any other opcode raises an error and leaves the program counter where it was.

Instructions enter on a valid/ready handshake. `ins_ready` is high only while the unit is idle. Results stay on the outputs from the end of one instruction until the next instruction is accepted.

Top module: `rel_branch_unit`

## Requirements
- R1: An instruction is accepted in the cycle where `ins_valid` and `ins_ready` are both high. That cycle is cycle 1. `ins_ready` is high only when the unit is idle. The flags, `irq_level`, `ins_addr`, `ins_disp` and `sp_in` are sampled only in cycle 1. Later changes to them do not affect the result.
- R2: Every opcode in 0x20..0x2F raises `done` for one cycle, in cycle 3, whether or not the branch is taken. `ins_ready` returns high in the next cycle.
- R3: For opcodes 0x20..0x2F, the condition is selected by opcode bits [3:1]:
  - 0: true
  - 1: C|Z = 0
  - 2: C = 0
  - 3: Z = 0
  - 4: H = 0
  - 5: N = 0
  - 6: I = 0
  - 7: interrupt pin low

  Opcode bit 0 = 0 branches when the condition is true, and bit 0 = 1 branches when it is false. `taken` reports the decision.
- R4: Opcode 0x20 is always taken and 0x21 is never taken, whatever the flags. Both still complete in 3 cycles.
- R5: The sequential address is `ins_addr` + 2. A taken branch sets `pc_next` to the sequential address plus the sign-extended displacement, modulo 2^16. A branch that is not taken sets `pc_next` to the sequential address.
- R6: Opcode 0xAD is always taken and sets `pc_next` as in R5. With `stk_ready` held high it raises `done` in cycle 6.
- R7: Opcode 0xAD writes the return address (`ins_addr` + 2) as two stack transfers:
  - first, the low byte at address `sp_in`;
  - then, the high byte at address `sp_in` − 1.

  The stack pointer drops by one after each accepted transfer, and `sp_out` equals `sp_in` − 2 at `done`.
- R8: While `stk_valid` is high and `stk_ready` is low, `stk_valid`, `stk_addr` and `stk_data` hold. Each such stall cycle delays `done` by exactly one cycle.
- R9: Any opcode outside 0x20..0x2F and other than 0xAD raises `done` in cycle 2 with `err` = 1, `taken` = 0, `pc_next` = `ins_addr` and `sp_out` = `sp_in`. It makes no stack write.
- R10: After reset `ins_ready` = 1, and `done`, `taken`, `err` and `stk_valid` are 0. `pc_next` and `sp_out` are 0.
- R11: `pc_next`, `taken`, `err` and `sp_out` keep their values from `done` until the next instruction is accepted. Branches (0x20..0x2F) leave `sp_out` equal to `sp_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, can accept an instruction |
| ins_opcode | input | 8 | Opcode byte |
| ins_disp | input | 8 | Signed displacement byte |
| ins_addr | input | 16 | Address of the opcode byte |
| sp_in | input | 16 | Stack pointer at acceptance |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| irq_level | input | 1 | Level of the external interrupt pin |
| done | output | 1 | One-cycle strobe on the last cycle of an instruction |
| taken | output | 1 | Branch decision of the last instruction |
| err | output | 1 | Last instruction had an illegal opcode |
| pc_next | output | 16 | Next program counter |
| sp_out | output | 16 | Current stack pointer |
| stk_valid | output | 1 | Stack write offered |
| stk_ready | input | 1 | Stack write accepted |
| stk_addr | output | 16 | Stack write address |
| stk_data | output | 8 | Stack write byte |

## Verification
A wrong sequencer state shows at the ports within the instruction where it happens:
- `done` arrives in the wrong cycle;
- `ins_ready` comes back early;
- `stk_valid` is raised for a branch.

The bench counts cycles from acceptance to `done` for every instruction, so such an error is caught within six cycles plus stalls. A corrupted stack pointer or return-address register shows as a wrong `stk_addr` or byte order on the same call, and as a wrong `sp_out` at its `done`. Flags are scrambled right after acceptance, so sampling them in the wrong cycle shows up as a wrong `taken` at the very next `done`.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam logic [7:0] OP_BSR    = 8'hAD;
  localparam logic [3:0] BR_GROUP  = 4'h2;
  localparam int         INSTR_LEN = 2;

  typedef struct packed {
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } ccr_t;

  typedef enum logic [1:0] {
    K_ILL,
    K_BR,
    K_BSR
  } kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PREP,
    S_PUSH,
    S_WAIT
  } state_t;
endpackage

// File: rtl/rbu_cond.sv
module rbu_cond
  import rbu_pkg::*;
(
  input  logic [7:0] opcode,
  input  ccr_t       ccr,
  input  logic       pin,
  output kind_t      kind,
  output logic       taken
);
  logic [7:0] truth;

  // one truth bit per condition pair, indexed by opcode[3:1]
  always_comb begin
    truth[0] = 1'b1;
    truth[1] = ~(ccr.c | ccr.z);
    truth[2] = ~ccr.c;
    truth[3] = ~ccr.z;
    truth[4] = ~ccr.h;
    truth[5] = ~ccr.n;
    truth[6] = ~ccr.i;
    truth[7] = ~pin;
  end

  always_comb begin
    if (opcode[7:4] == BR_GROUP) begin
      kind  = K_BR;
      taken = truth[opcode[3:1]] ^ opcode[0];
    end else if (opcode == OP_BSR) begin
      kind  = K_BSR;
      taken = 1'b1;
    end else begin
      kind  = K_ILL;
      taken = 1'b0;
    end
  end
endmodule

// File: rtl/rbu_target.sv
module rbu_target
  import rbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] disp,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] tgt_addr
);
  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp[DATA_W-1]}}, disp};
  assign seq_addr = op_addr + ADDR_W'(INSTR_LEN);
  assign tgt_addr = seq_addr + disp_ext;
endmodule

// File: rtl/rbu_ctrl.sv
module rbu_ctrl
  import rbu_pkg::*;
#(
  parameter int BR_CYCLES  = 3,
  parameter int BSR_CYCLES = 6,
  parameter int NBYTES     = 2,
  parameter int IDX_W      = 1,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  kind_t            kind,
  input  logic             stk_ready,
  output logic             ins_ready,
  output logic             stk_valid,
  output logic [IDX_W-1:0] byte_idx,
  output logic             push_fire,
  output logic             done
);
  // acceptance cycle, one prepare cycle, NBYTES push cycles, then the wait tail
  localparam logic [CNT_W-1:0] BR_WAIT  = CNT_W'(BR_CYCLES - 2);
  localparam logic [CNT_W-1:0] BSR_WAIT = CNT_W'(BSR_CYCLES - 3 - NBYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  assign ins_ready = (state == S_IDLE);
  assign stk_valid = (state == S_PUSH);
  assign push_fire = stk_valid && stk_ready;
  assign done      = (state == S_WAIT) && (cnt == '0);
  assign byte_idx  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            unique case (kind)
              K_BR: begin
                state <= S_WAIT;
                cnt   <= BR_WAIT;
              end
              K_BSR: begin
                state <= S_PREP;
              end
              default: begin
                state <= S_WAIT;
                cnt   <= '0;
              end
            endcase
          end
        end
        S_PREP: begin
          state <= S_PUSH;
          idx   <= '0;
        end
        S_PUSH: begin
          if (stk_ready) begin
            if (idx == LAST_IDX) begin
              state <= S_WAIT;
              cnt   <= BSR_WAIT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BR_CYCLES  = 3,
  parameter int BSR_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [7:0]        ins_opcode,
  input  logic [DATA_W-1:0] ins_disp,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              flag_h,
  input  logic              flag_i,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              irq_level,
  output logic              done,
  output logic              taken,
  output logic              err,
  output logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] sp_out,
  output logic              stk_valid,
  input  logic              stk_ready,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_data
);
  localparam int NBYTES = ADDR_W / DATA_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_W  = $clog2(BR_CYCLES + BSR_CYCLES + 1);

  ccr_t              ccr;
  kind_t             kind;
  logic              cond_taken;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] tgt_addr;
  logic              accept;
  logic [IDX_W-1:0]  byte_idx;
  logic              push_fire;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] ret_q;
  logic              taken_q;
  logic              err_q;

  assign ccr    = ccr_t'({flag_h, flag_i, flag_n, flag_z, flag_c});
  assign accept = ins_valid && ins_ready;

  rbu_cond u_cond (
    .opcode (ins_opcode),
    .ccr    (ccr),
    .pin    (irq_level),
    .kind   (kind),
    .taken  (cond_taken)
  );

  rbu_target #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_target (
    .op_addr  (ins_addr),
    .disp     (ins_disp),
    .seq_addr (seq_addr),
    .tgt_addr (tgt_addr)
  );

  rbu_ctrl #(
    .BR_CYCLES  (BR_CYCLES),
    .BSR_CYCLES (BSR_CYCLES),
    .NBYTES     (NBYTES),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind      (kind),
    .stk_ready (stk_ready),
    .ins_ready (ins_ready),
    .stk_valid (stk_valid),
    .byte_idx  (byte_idx),
    .push_fire (push_fire),
    .done      (done)
  );

  // results are captured once, in the acceptance cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      sp_q    <= '0;
      ret_q   <= '0;
      taken_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      ret_q <= seq_addr;
      sp_q  <= sp_in;
      unique case (kind)
        K_BR: begin
          taken_q <= cond_taken;
          pc_q    <= cond_taken ? tgt_addr : seq_addr;
          err_q   <= 1'b0;
        end
        K_BSR: begin
          taken_q <= 1'b1;
          pc_q    <= tgt_addr;
          err_q   <= 1'b0;
        end
        default: begin
          taken_q <= 1'b0;
          pc_q    <= ins_addr;
          err_q   <= 1'b1;
        end
      endcase
    end else if (push_fire) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  // return address split into stack bytes, least significant first
  logic [DATA_W-1:0] ret_bytes [NBYTES];
  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_ret_byte
    assign ret_bytes[gi] = ret_q[gi*DATA_W +: DATA_W];
  end

  assign stk_addr = sp_q;
  assign stk_data = ret_bytes[byte_idx];
  assign sp_out   = sp_q;
  assign pc_next  = pc_q;
  assign taken    = taken_q;
  assign err      = err_q;
endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              done,
  input logic              taken,
  input logic              err,
  input logic              stk_valid,
  input logic              stk_ready,
  input logic [ADDR_W-1:0] stk_addr,
  input logic [DATA_W-1:0] stk_data,
  input logic [ADDR_W-1:0] sp_out
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_ready |=> !ins_ready);

  assert_no_push_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid |-> !ins_ready);

  assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ins_ready && !done);

  assert_sp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid && stk_ready |=> sp_out == ($past(sp_out) - ADDR_W'(1)));

  assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stk_valid && !stk_ready |=> stk_valid && $stable(stk_addr) && $stable(stk_data));

  assert_illegal_not_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> !taken);
endmodule

bind rel_branch_unit rbu_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_rbu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .done      (done),
  .taken     (taken),
  .err       (err),
  .stk_valid (stk_valid),
  .stk_ready (stk_ready),
  .stk_addr  (stk_addr),
  .stk_data  (stk_data),
  .sp_out    (sp_out)
);

// File: tb/rel_branch_unit_test.sv
module rel_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [7:0]  ins_opcode = '0;
  logic [7:0]  ins_disp = '0;
  logic [15:0] ins_addr = '0;
  logic [15:0] sp_in = '0;
  logic        flag_h = 0, flag_i = 0, flag_n = 0, flag_z = 0, flag_c = 0;
  logic        irq_level = 0;
  logic        done, taken, err;
  logic [15:0] pc_next, sp_out;
  logic        stk_valid;
  logic        stk_ready = 1'b1;
  logic [15:0] stk_addr;
  logic [7:0]  stk_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rel_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opcode(ins_opcode), .ins_disp(ins_disp), .ins_addr(ins_addr), .sp_in(sp_in),
    .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .irq_level(irq_level), .done(done), .taken(taken), .err(err), .pc_next(pc_next),
    .sp_out(sp_out), .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_addr(stk_addr),
    .stk_data(stk_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // condition per R3; flags packed as {h,i,n,z,c}
  function automatic bit exp_taken(input logic [7:0] op, input logic [4:0] f, input logic pin);
    bit c;
    if (op == 8'hAD) return 1'b1;
    if (op[7:4] != 4'h2) return 1'b0;
    case (op[3:1])
      3'd0: c = 1'b1;
      3'd1: c = !(f[0] || f[1]);
      3'd2: c = !f[0];
      3'd3: c = !f[1];
      3'd4: c = !f[4];
      3'd5: c = !f[2];
      3'd6: c = !f[3];
      default: c = !pin;
    endcase
    return op[0] ? !c : c;
  endfunction

  int          cyc, nw, stalls;
  logic [15:0] wr_addr [4];
  logic [7:0]  wr_data [4];
  bit          busy_ok;

  task automatic run_instr(input logic [7:0] op, input logic [7:0] disp, input logic [15:0] addr,
                           input logic [15:0] sp, input logic [4:0] f, input logic pin,
                           input bit stall_en, input bit hold_chk);
    logic [15:0] seq, tgt, e_pc, e_sp;
    bit e_tk, e_err, is_bsr;
    int e_cyc;
    logic [15:0] h_pc, h_sp;
    logic h_tk, h_err;
    seq = addr + 16'd2;
    tgt = seq + {{8{disp[7]}}, disp};
    is_bsr = (op == 8'hAD);
    e_err = !is_bsr && (op[7:4] != 4'h2);
    e_tk = exp_taken(op, f, pin);
    e_pc = e_err ? addr : (e_tk ? tgt : seq);
    e_sp = is_bsr ? sp - 16'd2 : sp;

    @(negedge clk);
    chk(ins_ready === 1'b1, "R1 ready when idle", 32'(ins_ready), 1);
    ins_valid = 1'b1; ins_opcode = op; ins_disp = disp; ins_addr = addr; sp_in = sp;
    {flag_h, flag_i, flag_n, flag_z, flag_c} = f; irq_level = pin;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    // R1: scramble sampled inputs after acceptance
    {flag_h, flag_i, flag_n, flag_z, flag_c} = 5'($urandom);
    irq_level = 1'($urandom); ins_disp = 8'($urandom); ins_addr = 16'($urandom);
    sp_in = 16'($urandom); ins_opcode = 8'($urandom);
    cyc = 2; nw = 0; stalls = 0; busy_ok = 1;
    while (1) begin
      stk_ready = stall_en ? 1'($urandom) : 1'b1;
      if (ins_ready) busy_ok = 0;
      if (stk_valid && stk_ready && nw < 4) begin
        wr_addr[nw] = stk_addr; wr_data[nw] = stk_data; nw++;
      end
      if (stk_valid && !stk_ready) stalls++;
      if (done) break;
      if (cyc > 80) begin
        chk(0, "R2 done never raised", 32'(cyc), 0);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    stk_ready = 1'b1;
    e_cyc = e_err ? 2 : (is_bsr ? 6 + stalls : 3);
    chk(busy_ok, "R1 ready low while busy", 32'(busy_ok), 1);
    chk(cyc == e_cyc, is_bsr ? "R6 R8 cycles" : (e_err ? "R9 cycles" : "R2 cycles"), 32'(cyc), 32'(e_cyc));
    chk(taken === e_tk, "R3 R4 taken", 32'(taken), 32'(e_tk));
    chk(pc_next === e_pc, "R5 pc_next", 32'(pc_next), 32'(e_pc));
    chk(err === e_err, "R9 err", 32'(err), 32'(e_err));
    chk(sp_out === e_sp, "R7 R11 sp_out", 32'(sp_out), 32'(e_sp));
    chk(nw == (is_bsr ? 2 : 0), "R7 R9 write count", 32'(nw), is_bsr ? 2 : 0);
    if (is_bsr && nw == 2) begin
      chk(wr_addr[0] === sp && wr_data[0] === seq[7:0], "R7 low byte first",
          {wr_addr[0], 8'h0, wr_data[0]}, {sp, 8'h0, seq[7:0]});
      chk(wr_addr[1] === sp - 16'd1 && wr_data[1] === seq[15:8], "R7 high byte second",
          {wr_addr[1], 8'h0, wr_data[1]}, {sp - 16'd1, 8'h0, seq[15:8]});
    end
    if (hold_chk) begin
      h_pc = pc_next; h_sp = sp_out; h_tk = taken; h_err = err;
      repeat (3) @(negedge clk);
      chk(pc_next === h_pc && sp_out === h_sp && taken === h_tk && err === h_err,
          "R11 results held", {pc_next, sp_out}, {h_pc, h_sp});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ins_ready === 1'b1 && done === 1'b0 && taken === 1'b0 && err === 1'b0 && stk_valid === 1'b0,
        "R10 reset flags", {ins_ready, done, taken, err, stk_valid}, 5'b10000);
    chk(pc_next === 16'h0 && sp_out === 16'h0, "R10 reset values", {pc_next, sp_out}, 0);

    // R4 directed: always / never, with all flags set and clear
    run_instr(8'h20, 8'h10, 16'h1000, 16'h00FF, 5'b11111, 1'b1, 0, 1);
    run_instr(8'h21, 8'h10, 16'h1000, 16'h00FF, 5'b00000, 1'b0, 0, 1);
    // R5 wrap forward and backward
    run_instr(8'h20, 8'h7F, 16'hFFF0, 16'h0050, 5'b0, 1'b0, 0, 0);
    run_instr(8'h20, 8'h80, 16'h0010, 16'h0050, 5'b0, 1'b0, 0, 0);
    // R3 pin and half-carry pairs
    run_instr(8'h2E, 8'h04, 16'h2000, 16'h0050, 5'b0, 1'b0, 0, 0);
    run_instr(8'h2F, 8'h04, 16'h2000, 16'h0050, 5'b0, 1'b0, 0, 0);
    run_instr(8'h29, 8'hFC, 16'h2000, 16'h0050, 5'b10000, 1'b0, 0, 0);
    // R6 R7 call, stack pointer wrap below zero
    run_instr(8'hAD, 8'h20, 16'h12FE, 16'h0001, 5'b0, 1'b0, 0, 1);
    // R8 call under back-pressure
    run_instr(8'hAD, 8'hF0, 16'h3456, 16'h00C0, 5'b0, 1'b0, 1, 1);
    // R9 illegal opcodes
    run_instr(8'h9D, 8'h33, 16'h4444, 16'h0080, 5'b0, 1'b0, 0, 1);
    run_instr(8'h30, 8'h33, 16'h4444, 16'h0080, 5'b0, 1'b0, 0, 0);

    for (int k = 0; k < 400; k++) begin
      int r;
      logic [7:0] op;
      r = int'($urandom % 10);
      if (r < 7)      op = 8'h20 + 8'($urandom % 16);
      else if (r < 9) op = 8'hAD;
      else            op = 8'($urandom);
      run_instr(op, 8'($urandom), 16'($urandom), 16'($urandom), 5'($urandom),
                1'($urandom), 1'($urandom), (k % 7) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule